// File: doc/BRIEF.md
# Serial Configuration EEPROM Read Slave

This block stands in for a small read-only serial configuration memory of the kind that holds a station address. It has a three-wire serial link (serial clock, data in, data out) and an active-high chip select. It runs on a system clock. The serial clock is sampled, and each rising edge seen while chip select is high moves the command sequence forward by one bit.

A host raises chip select, then shifts in a start bit, a two-bit opcode and a six-bit word address, most significant bit first. After the last address bit the block returns the addressed 16-bit word, most significant bit first, one bit per serial clock rise. It then steps to the next word and keeps streaming for as long as chip select stays high. The memory holds 64 words and is loaded at reset from a parameter image. Only the read opcode is accepted.

The sequencer has four states. `ST_IDLE` waits for a start bit and goes to `ST_OP` on a 1. `ST_OP` collects two opcode bits. It goes to `ST_ADDR` on the read code, and back to `ST_IDLE` on any other code. `ST_ADDR` collects six address bits and then goes to `ST_DATA`. `ST_DATA` streams words until chip select drops. A low chip select sends every state back to `ST_IDLE`.

Top module: `mwr_eeprom`

## Requirements
- R1: After reset `dout` is 0 and the block waits for a start bit.
- R2: State advances only on a serial clock rise seen while `cs` is high. Serial clock activity while `cs` is low changes nothing.
- R3: While `cs` is low, `dout` is 0 from the next system clock edge onwards. The bit count, opcode and address are cleared, and a later command is decoded from its start bit.
- R4: While waiting for a start bit, a 0 bit keeps the block waiting and a 1 bit begins opcode capture.
- R5: The opcode is two bits, MSB first. Only binary 10 (read) is accepted. Any other code returns the block to waiting for a start bit, with no data phase.
- R6: The word address is six bits, MSB first, and follows the opcode.
- R7: Each word is returned as 16 bits, MSB first. The first bit appears on the serial clock rise after the last address bit, and each bit appears one system clock after the edge that first sees the serial clock high.
- R8: After the last bit of a word, the address increments and the next word streams without a new command.
- R9: During sequential reads the address wraps from 63 to 0.
- R10: `dout` is 0 outside the data phase, including while the start bit, opcode and address are shifted in.
- R11: Word i of the default image equals ({2'b00,i[5:0],2'b00,i[5:0]} XOR 16'hC3A5). The contents cannot be changed through the serial link.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs | input | 1 | Chip select, active high |
| sk | input | 1 | Serial clock from the host |
| di | input | 1 | Serial data from the host |
| dout | output | 1 | Serial data to the host |

## Verification
A serial clock rise is seen at the first system clock edge where `sk` is high. State and `dout` both update at that edge, so each data bit is due one system clock after the rise. The bench holds each serial clock phase for three system clocks and samples `dout` on a falling system clock edge at the end of the high phase, well after that update. A drop of chip select clears `dout` at the next system clock edge, and the bench checks `dout` two clocks later. Expected words come from the image formula and do not depend on the design.

// File: rtl/mwr_pkg.sv
package mwr_pkg;
    localparam int AW    = 6;
    localparam int DW    = 16;
    localparam int WORDS = 1 << AW;
    localparam int OPW   = 2;
    localparam logic [OPW-1:0] READ_OP = 2'b10;
    localparam logic [DW-1:0]  IMG_XOR = 16'hC3A5;

    typedef logic [WORDS-1:0][DW-1:0] image_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_OP   = 2'd1,
        ST_ADDR = 2'd2,
        ST_DATA = 2'd3
    } mwr_state_t;

    function automatic image_t default_image();
        image_t img;
        for (int i = 0; i < WORDS; i++) begin
            img[i] = DW'(i * 257) ^ IMG_XOR;
        end
        return img;
    endfunction
endpackage

// File: rtl/mwr_edge.sv
module mwr_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic sk,
    output logic sk_rise
);
    logic sk_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sk_q <= 1'b0;
        else        sk_q <= sk;
    end

    assign sk_rise = sk & ~sk_q;
endmodule

// File: rtl/mwr_rom.sv
module mwr_rom #(
    parameter mwr_pkg::image_t IMAGE = mwr_pkg::default_image()
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [mwr_pkg::AW-1:0] addr,
    output logic [mwr_pkg::DW-1:0] rd_word
);
    mwr_pkg::image_t mem;

    // Loaded at reset only; no write path exists.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mem <= IMAGE;
        else        mem <= mem;
    end

    assign rd_word = mem[addr];
endmodule

// File: rtl/mwr_fsm.sv
module mwr_fsm
    import mwr_pkg::*;
#(
    parameter int CW = $clog2(DW + 1),
    parameter int IW = $clog2(DW)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs,
    input  logic          sk_rise,
    input  logic          di,
    input  logic [DW-1:0] rd_word,
    output mwr_state_t    state,
    output logic [CW-1:0] bit_cnt,
    output logic [AW-1:0] word_addr,
    output logic          dout
);
    mwr_state_t     state_n;
    logic [CW-1:0]  cnt_n;
    logic [AW-1:0]  addr_n;
    logic [OPW-1:0] op_q, op_n;
    logic [IW-1:0]  bit_idx;

    assign bit_idx = IW'(bit_cnt - 1'b1);

    always_comb begin
        state_n = state;
        cnt_n   = bit_cnt;
        addr_n  = word_addr;
        op_n    = op_q;
        if (!cs) begin
            state_n = ST_IDLE;
            cnt_n   = '0;
            addr_n  = '0;
            op_n    = '0;
        end else if (sk_rise) begin
            unique case (state)
                ST_IDLE: begin
                    if (di) begin
                        state_n = ST_OP;
                        cnt_n   = '0;
                    end
                end
                ST_OP: begin
                    op_n  = {op_q[OPW-2:0], di};
                    cnt_n = bit_cnt + 1'b1;
                    if (bit_cnt == CW'(OPW - 1)) begin
                        cnt_n = '0;
                        if ({op_q[OPW-2:0], di} == READ_OP) begin
                            state_n = ST_ADDR;
                        end else begin
                            state_n = ST_IDLE;
                            op_n    = '0;
                        end
                    end
                end
                ST_ADDR: begin
                    addr_n = {word_addr[AW-2:0], di};
                    cnt_n  = bit_cnt + 1'b1;
                    if (bit_cnt == CW'(AW - 1)) begin
                        state_n = ST_DATA;
                        cnt_n   = CW'(DW);
                    end
                end
                ST_DATA: begin
                    cnt_n = bit_cnt - 1'b1;
                    if (bit_cnt == CW'(1)) begin
                        cnt_n  = CW'(DW);
                        addr_n = word_addr + 1'b1;
                    end
                end
                default: state_n = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            bit_cnt   <= '0;
            word_addr <= '0;
            op_q      <= '0;
        end else begin
            state     <= state_n;
            bit_cnt   <= cnt_n;
            word_addr <= addr_n;
            op_q      <= op_n;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       dout <= 1'b0;
        else if (!cs)     dout <= 1'b0;
        else if (sk_rise) dout <= (state == ST_DATA) ? rd_word[bit_idx] : 1'b0;
    end
endmodule

// File: rtl/mwr_eeprom.sv
module mwr_eeprom #(
    parameter mwr_pkg::image_t IMAGE = mwr_pkg::default_image()
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs,
    input  logic sk,
    input  logic di,
    output logic dout
);
    localparam int CW = $clog2(mwr_pkg::DW + 1);

    logic                   sk_rise;
    mwr_pkg::mwr_state_t    state;
    logic [CW-1:0]          bit_cnt;
    logic [mwr_pkg::AW-1:0] word_addr;
    logic [mwr_pkg::DW-1:0] rd_word;

    mwr_edge u_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .sk      (sk),
        .sk_rise (sk_rise)
    );

    mwr_rom #(.IMAGE(IMAGE)) u_rom (
        .clk     (clk),
        .rst_n   (rst_n),
        .addr    (word_addr),
        .rd_word (rd_word)
    );

    mwr_fsm #(.CW(CW)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs        (cs),
        .sk_rise   (sk_rise),
        .di        (di),
        .rd_word   (rd_word),
        .state     (state),
        .bit_cnt   (bit_cnt),
        .word_addr (word_addr),
        .dout      (dout)
    );
endmodule

// File: rtl/mwr_eeprom_chk.sv
module mwr_eeprom_chk
    import mwr_pkg::*;
#(
    parameter int CW = 5
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cs,
    input logic          di,
    input logic          sk_rise,
    input mwr_state_t    state,
    input logic [CW-1:0] bit_cnt,
    input logic [AW-1:0] word_addr,
    input logic          dout
);
    AST_CS_LOW_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !cs |=> (!dout && state == ST_IDLE)); // R3

    AST_HOLD_NO_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        (cs && !sk_rise) |=> ($stable(state) && $stable(word_addr))); // R2

    AST_DOUT_OUTSIDE_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_DATA) |-> !dout); // R10

    AST_START_ZERO_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        (cs && sk_rise && state == ST_IDLE && !di) |=> state == ST_IDLE); // R4

    AST_START_ONE_GO: assert property (@(posedge clk) disable iff (!rst_n)
        (cs && sk_rise && state == ST_IDLE && di) |=> state == ST_OP); // R4

    AST_WORD_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (cs && sk_rise && state == ST_DATA && bit_cnt == CW'(1))
        |=> word_addr == AW'($past(word_addr) + 1'b1)); // R8
endmodule

bind mwr_eeprom mwr_eeprom_chk #(.CW(CW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs        (cs),
    .di        (di),
    .sk_rise   (sk_rise),
    .state     (state),
    .bit_cnt   (bit_cnt),
    .word_addr (word_addr),
    .dout      (dout)
);

// File: tb/sim_mwr_eeprom.sv
`timescale 1ns/1ps
module sim_mwr_eeprom;
    logic clk = 1'b0;
    logic rst_n, cs, sk, di;
    logic dout;
    int   n_chk = 0;
    int   n_err = 0;

    always #2.5 clk = ~clk;

    mwr_eeprom u0 (.clk(clk), .rst_n(rst_n), .cs(cs), .sk(sk), .di(di), .dout(dout));

    function automatic logic [15:0] exp_word(input int a);
        return 16'((a % 64) * 257) ^ 16'hC3A5;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse(input logic b, output logic s);
        di = b;
        sk = 1'b0;
        wait_clk(3);
        sk = 1'b1;
        wait_clk(3);
        s  = dout;
        sk = 1'b0;
    endtask

    // bits shifted in with dout required low throughout (R10)
    task automatic shift_quiet(input logic [15:0] bits, input int n, input string req);
        logic s;
        logic any = 1'b0;
        for (int i = n - 1; i >= 0; i--) begin
            pulse(bits[i], s);
            any |= s;
        end
        chk(!any, req, 16'(any), 16'h0);
    endtask

    task automatic read_cmd(input int a);
        shift_quiet({7'b0, 3'b110, 6'(a)}, 9, "R10");
    endtask

    task automatic read_word(input int a, input string req);
        logic [15:0] w;
        logic s;
        for (int i = 15; i >= 0; i--) begin
            pulse(1'b0, s);
            w[i] = s;
        end
        chk(w == exp_word(a), req, w, exp_word(a));
    endtask

    task automatic cs_drop;
        di = 1'b0;
        sk = 1'b0;
        cs = 1'b0;
        wait_clk(2);
        chk(dout == 1'b0, "R3", 16'(dout), 16'h0);
        wait_clk(2);
    endtask

    initial begin
        int start_ok;
        rst_n = 1'b0; cs = 1'b0; sk = 1'b0; di = 1'b0;
        wait_clk(4);
        rst_n = 1'b1;
        wait_clk(2);
        chk(dout == 1'b0, "R1", 16'(dout), 16'h0);

        // R1: first command after reset decodes from its start bit
        cs = 1'b1;
        read_cmd(7);
        read_word(7, "R1");
        cs_drop();

        // R2: serial activity with cs low is ignored
        shift_quiet(16'b1_10_000011, 9, "R2");
        shift_quiet(16'hFFFF, 16, "R2");
        cs = 1'b1;
        read_cmd(5);
        read_word(5, "R2");
        cs_drop();

        // R4: leading zeros keep the block waiting
        cs = 1'b1;
        shift_quiet(16'h0, 5, "R4");
        read_cmd(9);
        read_word(9, "R4");
        cs_drop();

        // R5: non-read opcodes abort to start-bit wait
        for (int op = 0; op < 4; op++) begin
            if (op == 2) continue;
            cs = 1'b1;
            shift_quiet(16'({1'b1, 2'(op)}), 3, "R5");
            shift_quiet(16'h0, 16, "R5");
            shift_quiet(16'h0, 8, "R5");
            read_cmd(17 + op);
            read_word(17 + op, "R5");
            cs_drop();
        end

        // R11: a write-like command then a read of the same word
        cs = 1'b1;
        shift_quiet({7'b0, 3'b101, 6'd33}, 9, "R11");
        shift_quiet(16'h0000, 16, "R11");
        cs_drop();
        cs = 1'b1;
        read_cmd(33);
        read_word(33, "R11");
        cs_drop();

        // R3: drop cs mid-word, then a fresh read
        cs = 1'b1;
        read_cmd(12);
        for (int i = 0; i < 7; i++) begin
            logic s;
            pulse(1'b0, s);
        end
        cs_drop();
        cs = 1'b1;
        read_cmd(40);
        read_word(40, "R3");
        cs_drop();

        // R6 R7 R11: every address
        for (int a = 0; a < 64; a++) begin
            cs = 1'b1;
            read_cmd(a);
            read_word(a, "R7");
            cs_drop();
        end

        // R8: sequential stream
        cs = 1'b1;
        read_cmd(20);
        for (int k = 0; k < 4; k++) read_word(20 + k, "R8");
        cs_drop();

        // R9: wrap from 63 to 0
        cs = 1'b1;
        read_cmd(62);
        for (int k = 0; k < 4; k++) read_word(62 + k, "R9");
        cs_drop();

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog actual=%h expected=%h", 16'h1, 16'h0);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule